// File: doc/BRIEF.md
# Slot-Table Memory Arbiter

This block decides which of fourteen clients owns a shared memory port on each grant opportunity. Bandwidth is shared out through a table of 64 time slots, and each slot names one client. There are two tables, one for each memory region, and each has its own slot pointer. On every cycle the region select input picks the table and pointer in use. If the client named in the current slot is requesting, it wins. If that client is idle, or the slot holds a value that names no client, the slot goes to the lowest-numbered requesting client.

The grant is registered and one-hot. It appears in the cycle after the request vector that produced it. The pointer of the selected region moves forward one slot each time a grant is issued and wraps from the last slot back to slot 0. When nothing is requested, the block issues no grant and the pointer stays where it is. Slot entries are rewritten at run time through a write port that takes a region, a slot index and a client value. A write lands at the clock edge, so it affects grant decisions from the next cycle onward. Software changes bandwidth shares by giving a client more or fewer slots.

Top module: `slot_arbiter`

## Requirements
- R1: After reset the grant output is all zero, both slot pointers are at slot 0, and every slot in both tables holds the unowned value 15. Until slots are programmed, grants therefore follow the lowest-index rule.
- R2: When the client index held in the current slot of the selected region is requesting, that client alone receives the grant.
- R3: When the current slot's client is valid but not requesting, the grant goes to the lowest-numbered requesting client.
- R4: A slot value of 14 or 15 marks the slot as unowned. Such a slot always grants the lowest-numbered requesting client.
- R5: When the request vector is all zero, the next grant is all zero and neither slot pointer moves.
- R6: Each issued grant advances the selected region's pointer by exactly one slot, and the pointer wraps from 63 to 0.
- R7: The two regions keep separate tables and separate pointers. Only the pointer of the region selected in a cycle can advance, and the other region's pointer holds.
- R8: A slot write (region bit, 6-bit slot index, 4-bit client value) is used by decisions from the cycle after the write edge. A decision made in the write cycle itself uses the old entry, and a write to one region leaves the other region's table unchanged.
- R9: The grant is registered, one cycle after the request it answers. It is one-hot or zero, and it never names a client that was not requesting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 14 | Request vector, bit i for client i |
| region_sel | input | 1 | Region whose table and pointer are used this cycle |
| tbl_wr_en | input | 1 | Slot write strobe |
| tbl_wr_region | input | 1 | Region of the slot being written |
| tbl_wr_slot | input | 6 | Index of the slot being written |
| tbl_wr_client | input | 4 | New slot value; values 14 and 15 mean unowned |
| gnt | output | 14 | Registered one-hot grant |

## Verification
The bench targets several corner cases, each of which shows up as a wrong grant.
- Pointer wrap: after more than 64 back-to-back grants, a design with an off-by-one wrap hands later slots to the wrong owners.
- Idle owners: requests that leave out exactly the current owner catch a design that grants the idle owner, or that falls back to some index other than the lowest.
- Unowned slot values: unowned entries mixed into the second table expose a design that decodes 14 or 15 as a client.
- Region handling: cycles that switch region at random show whether one region's pointer leaks into the other.
- Idle cycles: cycles with no requests show whether the pointer drifts while nothing is granted.
- Write timing: writes aimed at the slot being used in that same cycle check that the old entry decides the grant.

// File: rtl/slot_arb_pkg.sv
// Shared defaults and helper types for the slot-table arbiter.
// Assumes: the client field is wide enough to hold one value above the
// highest client index, which serves as the unowned marker.
package slot_arb_pkg;
    localparam int unsigned DEF_CLIENTS = 14;
    localparam int unsigned DEF_SLOTS   = 64;
    localparam int unsigned DEF_REGIONS = 2;
endpackage

// File: rtl/lowest_first.sv
// Fixed-priority picker: returns a one-hot vector marking the lowest set
// bit of the request vector, or zero when no bit is set.
// Assumes: purely combinational, N >= 1.
module lowest_first #(
    parameter int unsigned N = 14
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    // Isolate the lowest set bit with the two's complement trick.
    always_comb begin
        pick = req & (~req + N'(1));
    end
endmodule

// File: rtl/slot_table.sv
// One region's slot table: SLOTS entries of CW bits, one write port and
// one asynchronous read port. Every entry resets to all ones (unowned).
// Assumes: CW is wide enough that all ones is not a valid client index.
module slot_table #(
    parameter int unsigned SLOTS = 64,
    parameter int unsigned CW    = 4,
    localparam int unsigned SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [CW-1:0] wr_val,
    input  logic [SW-1:0] rd_slot,
    output logic [CW-1:0] rd_val
);
    logic [CW-1:0] entry_q [SLOTS];

    // Store a new slot value, or clear all entries to unowned on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                entry_q[i] <= '1;
            end
        end else if (wr_en) begin
            entry_q[wr_slot] <= wr_val;
        end
    end

    // Present the entry at the read index.
    always_comb begin
        rd_val = entry_q[rd_slot];
    end
endmodule

// File: rtl/grant_pick.sv
// Decides the next grant: the slot's owner when it is valid and
// requesting, otherwise the lowest-numbered requester.
// Assumes: owner values at or above N are unowned markers.
module grant_pick #(
    parameter int unsigned N  = 14,
    parameter int unsigned CW = 4
) (
    input  logic [N-1:0]  req,
    input  logic [CW-1:0] owner,
    output logic [N-1:0]  next_gnt
);
    logic [N-1:0] owner_dec;
    logic [N-1:0] fallback;
    logic         owner_live;

    // Decode the owner into a one-hot; unowned values decode to zero.
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign owner_dec[i] = (owner == CW'(i));
    end

    lowest_first #(.N(N)) u_fallback (
        .req  (req),
        .pick (fallback)
    );

    // Choose between the owner and the fixed-priority fallback.
    always_comb begin
        owner_live = |(owner_dec & req);
        next_gnt   = owner_live ? owner_dec : fallback;
    end
endmodule

// File: rtl/slot_arbiter.sv
// Slot-table arbiter top. It keeps one table and one pointer per region,
// picks a registered one-hot grant each cycle, and advances the selected
// region's pointer once for each grant issued.
// Assumes: region_sel is below REGIONS; slot writes come from a single
// programming agent.
module slot_arbiter
    import slot_arb_pkg::*;
#(
    parameter int unsigned CLIENTS = DEF_CLIENTS,
    parameter int unsigned SLOTS   = DEF_SLOTS,
    parameter int unsigned REGIONS = DEF_REGIONS,
    localparam int unsigned CW = $clog2(CLIENTS + 1),
    localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int unsigned RW = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CLIENTS-1:0] req,
    input  logic [RW-1:0]      region_sel,
    input  logic               tbl_wr_en,
    input  logic [RW-1:0]      tbl_wr_region,
    input  logic [SW-1:0]      tbl_wr_slot,
    input  logic [CW-1:0]      tbl_wr_client,
    output logic [CLIENTS-1:0] gnt
);
    logic [SW-1:0]      ptr_q     [REGIONS];
    logic [CW-1:0]      owner_r   [REGIONS];
    logic [CW-1:0]      cur_owner;
    logic [CLIENTS-1:0] next_gnt;
    logic               any_req;

    // One table per region; each sees only writes addressed to it.
    for (genvar g = 0; g < REGIONS; g++) begin : g_region
        slot_table #(.SLOTS(SLOTS), .CW(CW)) u_table (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (tbl_wr_en && (tbl_wr_region == RW'(g))),
            .wr_slot (tbl_wr_slot),
            .wr_val  (tbl_wr_client),
            .rd_slot (ptr_q[g]),
            .rd_val  (owner_r[g])
        );

        // Step this region's pointer when it is selected and a grant issues.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[g] <= '0;
            end else if (any_req && (region_sel == RW'(g))) begin
                ptr_q[g] <= (ptr_q[g] == SW'(SLOTS - 1)) ? '0 : ptr_q[g] + SW'(1);
            end
        end

        AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (any_req && region_sel == RW'(g)) |=>
            (ptr_q[g] == (($past(ptr_q[g]) == SW'(SLOTS - 1)) ? '0 : $past(ptr_q[g]) + SW'(1)))); // R6
        AST_PTR_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (region_sel != RW'(g)) |=> $stable(ptr_q[g])); // R7
        AST_PTR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!any_req) |=> $stable(ptr_q[g])); // R5
    end

    // Select the current slot owner of the active region.
    always_comb begin
        any_req   = |req;
        cur_owner = owner_r[region_sel];
    end

    grant_pick #(.N(CLIENTS), .CW(CW)) u_pick (
        .req      (req),
        .owner    (cur_owner),
        .next_gnt (next_gnt)
    );

    // Register the grant; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt <= '0;
        end else begin
            gnt <= next_gnt;
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R9
    AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((gnt & ~$past(req)) == '0)); // R9
    AST_NO_REQ_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_req) |=> (gnt == '0)); // R5
    AST_REQ_GETS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> (gnt != '0)); // R3
endmodule

// File: tb/slot_arbiter_bench.sv
module slot_arbiter_bench;
    localparam int NC = 14;
    localparam int NS = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] req = '0;
    logic          region_sel = 1'b0;
    logic          tbl_wr_en = 1'b0;
    logic          tbl_wr_region = 1'b0;
    logic [5:0]    tbl_wr_slot = '0;
    logic [3:0]    tbl_wr_client = '0;
    logic [NC-1:0] gnt;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int tbl [2][NS];
    int ptr [2];
    int lfsr = 32'h1ACE5;

    always #4 clk = ~clk;

    slot_arbiter u_slot_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .region_sel(region_sel),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_region(tbl_wr_region),
        .tbl_wr_slot(tbl_wr_slot), .tbl_wr_client(tbl_wr_client), .gnt(gnt)
    );

    function automatic int next_rand();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'h80200003 : 0);
        return lfsr;
    endfunction

    task automatic check(input logic [NC-1:0] exp, input string tag);
        checks++;
        if (gnt !== exp) begin
            failures++;
            $display("FAIL %s gnt=%h expected=%h", tag, gnt, exp);
        end
    endtask

    // Drive one cycle, predict the grant from the model, then compare.
    task automatic step(input logic [NC-1:0] r, input int rg, input bit we,
                        input int wrg, input int ws, input int wc, input string tag);
        logic [NC-1:0] exp;
        int own;
        @(negedge clk);
        req = r; region_sel = rg[0]; tbl_wr_en = we;
        tbl_wr_region = wrg[0]; tbl_wr_slot = ws[5:0]; tbl_wr_client = wc[3:0];
        exp = '0;
        own = tbl[rg][ptr[rg]];
        if (r != 0) begin
            if (own < NC && r[own]) exp[own] = 1'b1;
            else begin
                for (int i = NC - 1; i >= 0; i--) if (r[i]) begin exp = '0; exp[i] = 1'b1; end
            end
            ptr[rg] = (ptr[rg] + 1) % NS;
        end
        if (we) tbl[wrg][ws] = wc;
        @(posedge clk);
        #1;
        check(exp, tag);
    endtask

    initial begin
        for (int g = 0; g < 2; g++) begin
            ptr[g] = 0;
            for (int s = 0; s < NS; s++) tbl[g][s] = 15;
        end
        repeat (3) @(posedge clk);
        #1;
        check('0, "R1 reset grant");
        @(negedge clk);
        rst_n = 1'b1;
        // R1/R4: unowned slots after reset fall back to the lowest requester.
        step(14'h0014, 0, 0, 0, 0, 0, "R1 unowned after reset");
        step(14'h2000, 1, 0, 0, 0, 0, "R1 region1 unowned");
        // R5: idle cycles give no grant and leave pointers where they are.
        for (int k = 0; k < 4; k++) step('0, k % 2, 0, 0, 0, 0, "R5 idle");
        // R8: program both tables while idle.
        for (int s = 0; s < NS; s++) step('0, 0, 1, 0, s, s % NC, "R8 program region0");
        for (int s = 0; s < NS; s++)
            step('0, 1, 1, 1, s, (s % 5 == 0) ? 14 + (s % 2) : 13 - (s % NC), "R8 program region1");
        // R2/R6: every client requests; owners win slot by slot through wraps.
        for (int k = 0; k < 140; k++) step(14'h3FFF, 0, 0, 0, 0, 0, "R2 R6 owner wins with wrap");
        // R3: the current owner stays idle; the lowest other requester wins.
        for (int k = 0; k < 40; k++) begin
            logic [NC-1:0] r;
            r = 14'h3FFF;
            if (tbl[0][ptr[0]] < NC) r[tbl[0][ptr[0]]] = 1'b0;
            step(r, 0, 0, 0, 0, 0, "R3 idle owner fallback");
        end
        // R4: region1 holds unowned entries mixed with owners.
        for (int k = 0; k < 70; k++) step(14'h3FFF & ~14'h0003, 1, 0, 0, 0, 0, "R4 unowned slots");
        // R7: random requests with random region switching.
        for (int k = 0; k < 300; k++) begin
            int v;
            v = next_rand();
            step(v[13:0] & next_rand(), (next_rand() >> 3) & 1, 0, 0, 0, 0, "R7 region interleave");
        end
        // R8: writes aimed at the slot in use this cycle and at the other region.
        for (int k = 0; k < 60; k++) begin
            int wrg;
            wrg = (next_rand() >> 5) & 1;
            step(14'h3FFF & next_rand(), k % 2, 1, wrg, (k % 3 == 0) ? ptr[wrg] : next_rand() & 63,
                 next_rand() & 15, "R8 write timing");
        end
        // R9: single requesters, grant must name exactly that client.
        for (int i = 0; i < NC; i++) step(14'(1 << i), i % 2, 0, 0, 0, 0, "R9 single requester");
        step('0, 0, 0, 0, 0, 0, "R5 final idle");
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule